// File: doc/BRIEF.md
# Handshake Word Transfer Between Clock Domains

This block moves a counter word from a slow source clock domain into a faster destination clock domain. On the source side a counter advances by one and then offers the new value with a request line. On the destination side a receive controller sees the request after it passes through a chain of flip-flops, copies the word into a capture register, and answers with an acknowledge line. That line crosses back the same way. The handshake has four phases: request up, acknowledge up, request down, acknowledge down. The source does not offer the next value until the acknowledge has fallen again.

Because of this, every counter value reaches the destination once and in order. The data bus does not change while the destination may sample it, so the word needs no synchronizer of its own. Each clock domain has its own reset. Each reset is asserted asynchronously from a shared active-low input and released in step with the local clock.

Top module: `hs_cdc_xfer`

## Requirements
- R1: While reset is asserted, and until the first capture, `rx_word` is zero.
- R2: The first word delivered after reset is 1. The source counter starts at 0, and the first step of the transmit controller increments it.
- R3: Each change of `rx_word` is to the previous value plus one, modulo 2^DATA_W. No value is skipped.
- R4: Each new word reaches `rx_word` within a bounded number of destination cycles after the previous one. The source never stalls, and no transfer re-delivers an unchanged value.
- R5: After the all-ones value the counter wraps, and the next delivered word is zero.
- R6: Between captures, `rx_word` holds its value on every destination clock.
- R7: The source counter does not change while the request line is high.
- R8: The capture enable lasts exactly one destination cycle. The acknowledge rises on the clock that ends that cycle. It falls on the clock after the synchronized request is seen low.
- R9: The transmit controller lowers its request on the clock after it sees the synchronized acknowledge high. It does not step the counter again until that acknowledge is seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Slow source clock; drives the counter and the transmit controller |
| clk_dst | input | 1 | Fast destination clock; drives the capture register and the receive controller |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| rx_word | output | DATA_W | Last word captured in the destination domain |

## Verification
The counter can step and wrap to zero in the same source cycle. The wrapped word is then equal to the reset value of `rx_word`. A second instance, 4 bits wide, is used to provoke this overlap many times in one run. The reference model is judged at the wrap: after the all-ones value, the next value it accepts is zero, and it does not accept a return to any older value. The wide instance runs alongside the narrow one. On every destination clock the model checks that each output either holds its value or steps by exactly one.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;

  typedef enum logic [2:0] {
    TX_STEP  = 3'b001,
    TX_OFFER = 3'b010,
    TX_CLOSE = 3'b100
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE = 3'b001,
    RX_TAKE = 3'b010,
    RX_HOLD = 3'b100
  } rx_state_e;

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hs_tx_ctrl.sv
module hs_tx_ctrl
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_s,
  output logic              req,
  output logic [DATA_W-1:0] data
);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] cnt_q;
  logic              cnt_en;
  logic              req_q, req_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_STEP:  state_d = TX_OFFER;
      TX_OFFER: if (ack_s)  state_d = TX_CLOSE;
      TX_CLOSE: if (!ack_s) state_d = TX_STEP;
      default:  state_d = TX_STEP;
    endcase
  end

  assign cnt_en = (state_q == TX_STEP);
  assign req_d  = (state_d == TX_OFFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_STEP;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign req  = req_q;
  assign data = cnt_q;

  assert_cnt_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> $stable(cnt_q));

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && ack_s) |=> !req_q);

  assert_no_step_early_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && ack_s) |=> $stable(cnt_q));

endmodule

// File: rtl/hs_rx_ctrl.sv
module hs_rx_ctrl
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic [DATA_W-1:0] data_in,
  output logic              ack,
  output logic [DATA_W-1:0] rx_word
);

  rx_state_e         state_q, state_d;
  logic              cap_en;
  logic              ack_q, ack_d;
  logic [DATA_W-1:0] word_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RX_IDLE: if (req_s)  state_d = RX_TAKE;
      RX_TAKE: state_d = RX_HOLD;
      RX_HOLD: if (!req_s) state_d = RX_IDLE;
      default: state_d = RX_IDLE;
    endcase
  end

  assign cap_en = (state_q == RX_TAKE);

  always_comb begin
    ack_d = ack_q;
    if (cap_en)                              ack_d = 1'b1;
    else if (state_q == RX_HOLD && !req_s)   ack_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (cap_en) word_q <= data_in;
  end

  assign ack     = ack_q;
  assign rx_word = word_q;

  assert_cap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> !cap_en);

  assert_ack_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> ack_q);

  assert_ack_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !cap_en && !req_s) |=> !ack_q);

  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(word_q));

endmodule

// File: rtl/hs_cdc_xfer.sv
module hs_cdc_xfer #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_src,
  input  logic              clk_dst,
  input  logic              rst_n,
  output logic [DATA_W-1:0] rx_word
);

  logic              rst_src_n, rst_dst_n;
  logic              req, ack, req_s, ack_s;
  logic [DATA_W-1:0] bus;

  hs_sync2 #(.STAGES(2)) u_rst_src (
    .clk(clk_src), .rst_n(rst_n), .d(1'b1), .q(rst_src_n));

  hs_sync2 #(.STAGES(2)) u_rst_dst (
    .clk(clk_dst), .rst_n(rst_n), .d(1'b1), .q(rst_dst_n));

  hs_tx_ctrl #(.DATA_W(DATA_W)) u_tx (
    .clk(clk_src), .rst_n(rst_src_n), .ack_s(ack_s), .req(req), .data(bus));

  hs_sync2 #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_dst), .rst_n(rst_dst_n), .d(req), .q(req_s));

  hs_sync2 #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_src), .rst_n(rst_src_n), .d(ack), .q(ack_s));

  hs_rx_ctrl #(.DATA_W(DATA_W)) u_rx (
    .clk(clk_dst), .rst_n(rst_dst_n), .req_s(req_s), .data_in(bus),
    .ack(ack), .rx_word(rx_word));

  assert_bus_stable_R7: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
    req_s |=> (req_s || $stable(bus)) );

endmodule

// File: tb/hs_cdc_xfer_tb_top.sv
`timescale 1ns/100ps
module hs_cdc_xfer_tb_top;

  localparam int NARROW_W = 4;
  localparam int GAP_MAX  = 120;
  localparam int WD_LIMIT = 40000;

  logic clk_src = 1'b0;
  logic clk_dst = 1'b0;
  logic rst_n   = 1'b0;
  logic [15:0]         rx_wide;
  logic [NARROW_W-1:0] rx_narrow;

  always #10   clk_dst = ~clk_dst;
  always #45.5 clk_src = ~clk_src;

  hs_cdc_xfer #(.DATA_W(16)) dut_i (
    .clk_src(clk_src), .clk_dst(clk_dst), .rst_n(rst_n), .rx_word(rx_wide));

  hs_cdc_xfer #(.DATA_W(NARROW_W)) dut_n (
    .clk_src(clk_src), .clk_dst(clk_dst), .rst_n(rst_n), .rx_word(rx_narrow));

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int cur  [2];
  int seen [2];
  int gap  [2];
  int wraps;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk_dst) begin
    if (!done) begin
      cycles++;
      for (int k = 0; k < 2; k++) begin
        int act, mask, nxt;
        act  = (k == 0) ? int'(rx_wide) : int'(rx_narrow);
        mask = (k == 0) ? 32'hFFFF : ((1 << NARROW_W) - 1);
        if (!rst_n) begin
          chk(act == 0, "R1", act, 0);
        end else begin
          nxt = (cur[k] + 1) & mask;
          if (act == cur[k]) begin
            if (seen[k] == 0) chk(1'b1, "R1", act, 0);
            else              chk(1'b1, "R6", act, cur[k]);
            gap[k]++;
            if (gap[k] > GAP_MAX) begin
              chk(1'b0, "R4", gap[k], GAP_MAX);
              gap[k] = 0;
            end
          end else if (act == nxt) begin
            if (seen[k] == 0)  chk(act == 1, "R2", act, 1);
            else if (nxt == 0) begin
              chk(cur[k] == mask, "R5", cur[k], mask);
              if (k == 1) wraps++;
            end else           chk(1'b1, "R3", act, nxt);
            cur[k] = act;
            seen[k]++;
            gap[k] = 0;
          end else begin
            chk(1'b0, "R3", act, nxt);
            cur[k] = act;
            gap[k] = 0;
          end
        end
      end
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      cur[k] = 0; seen[k] = 0; gap[k] = 0;
    end
    wraps = 0;
    #100;
    @(negedge clk_src);
    rst_n = 1'b1;
    while (!(seen[0] >= 150 && seen[1] >= 40) && cycles < WD_LIMIT)
      @(negedge clk_dst);
    done = 1;
    if (cycles >= WD_LIMIT) chk(1'b0, "R4 watchdog", cycles, WD_LIMIT);
    chk(wraps >= 2, "R5", wraps, 2);
    chk(seen[0] >= 150, "R4", seen[0], 150);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule